// File: doc/BRIEF.md
# Printable-ASCII Six-Bit Symbol Codec

This block sits between an 8-bit byte transport and a consumer or producer of 6-bit symbols, and works in both directions. Incoming bytes that belong to a 64-character printable alphabet become 6-bit values. Digits, uppercase letters, lowercase letters, '@' and '%' make up the alphabet. A line-feed byte does not carry a symbol. It is forwarded as an out-of-band flag that tells the downstream logic to end any write in progress. The all-ones idle filler, carriage return and every other byte outside the alphabet are swallowed and produce no output.

Outgoing 6-bit values are turned back into their printable characters. A symbol presented with its newline flag set goes out as a line feed. When the transmitter has nothing to send and the idle-fill enable is high, it emits the all-ones idle byte, so that a link which must transmit in order to receive always has something to send. Every port group uses a valid/ready handshake. Each side holds one registered entry.

The receive side is a two-state machine. In RX_EMPTY no symbol is held. It moves to RX_HOLD when it accepts a byte that is kept. It stays in RX_HOLD while the output is stalled or a new kept byte replaces the consumed one. It returns to RX_EMPTY when the output is taken and no kept byte arrives. The transmit side has three states. TX_EMPTY means no byte is offered. TX_SYM means a character or line feed is offered. TX_FILL means an idle byte is offered. Whenever its slot is free (it is empty or its byte is being taken), it moves to TX_SYM if a symbol is pending, otherwise to TX_FILL if fill is enabled, otherwise to TX_EMPTY. While the slot is not free it stays where it is.

Top module: `sixbit_ascii_codec`

## Requirements
- R1: Values 0 to 9 correspond to bytes 8'h30 to 8'h39 ('0' to '9') on both the receive and the transmit path.
- R2: Values 10 to 35 correspond to bytes 8'h41 to 8'h5A ('A' to 'Z') on both paths.
- R3: Values 36 to 61 correspond to bytes 8'h61 to 8'h7A ('a' to 'z') on both paths.
- R4: Value 62 corresponds to 8'h40 ('@') and value 63 to 8'h25 ('%') on both paths.
- R5: A received 8'h0A produces one output with sym_out_nl = 1 and sym_out = 0.
- R6: A received byte outside the alphabet, including 8'hFF and 8'h0D, produces no output and changes no held output.
- R7: While sym_out_valid is high and sym_out_ready is low, sym_out and sym_out_nl hold their values, and the decoded stream keeps the input order.
- R8: A transmit input with sym_in_nl = 1 emits 8'h0A whatever the value on sym_in.
- R9: The byte 8'hFF is offered only when idle_fill_en is high and no symbol is pending. With fill enabled and the link idle, idle bytes flow continuously. With fill disabled, the output goes invalid once the last byte is taken.
- R10: While tx_byte_valid is high and tx_byte_ready is low, tx_byte holds its value. A pending symbol takes the next free slot ahead of fill.
- R11: During and directly after reset, sym_out_valid and tx_byte_valid are low and both input ready signals are high.
- R12: With the output ready held high, back-to-back kept bytes come out one per cycle, each one cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte_valid | input | 1 | Received byte is present |
| rx_byte_ready | output | 1 | Codec accepts the received byte |
| rx_byte | input | 8 | Received byte |
| sym_out_valid | output | 1 | Decoded symbol or newline is present |
| sym_out_ready | input | 1 | Consumer takes the decoded item |
| sym_out | output | 6 | Decoded symbol value (0 for a newline) |
| sym_out_nl | output | 1 | Decoded item is a newline marker |
| sym_in_valid | input | 1 | Symbol to transmit is present |
| sym_in_ready | output | 1 | Codec accepts the symbol |
| sym_in | input | 6 | Symbol value to transmit |
| sym_in_nl | input | 1 | Transmit a newline instead of a symbol |
| idle_fill_en | input | 1 | Allow idle bytes when nothing is pending |
| tx_byte_valid | output | 1 | Transmit byte is present |
| tx_byte_ready | input | 1 | Transport takes the transmit byte |
| tx_byte | output | 8 | Transmit byte |

## Verification
The bench builds the codec with its default parameters: line feed 8'h0A as the newline code and 8'hFF as the idle code. These are the values that make the newline marker, the idle drop and the idle fill reachable at all. With them it sweeps all 64 symbols through both paths, first with free-running and then with stalled ready signals, and mixes in out-of-alphabet bytes. It also toggles fill around pending symbols, which reaches the precedence of a symbol over fill and the return to an empty output once fill is turned off.

// File: rtl/codec_pkg.sv
package codec_pkg;

    localparam int SYM_W  = 6;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {K_SYM, K_NL, K_DROP} char_kind_e;
    typedef enum logic {RX_EMPTY, RX_HOLD} rx_state_e;
    typedef enum logic [1:0] {TX_EMPTY, TX_SYM, TX_FILL} tx_state_e;

    // value -> printable character
    function automatic logic [BYTE_W-1:0] sym_to_char(input logic [SYM_W-1:0] v);
        logic [BYTE_W-1:0] w;
        w = {2'b00, v};
        if (v < 6'd10)       return w + 8'h30;
        else if (v < 6'd36)  return w + 8'h37;
        else if (v < 6'd62)  return w + 8'h3D;
        else if (v == 6'd62) return 8'h40;
        else                 return 8'h25;
    endfunction

    // printable character -> {hit, value}
    function automatic logic [SYM_W:0] char_to_sym(input logic [BYTE_W-1:0] c);
        logic [BYTE_W-1:0] d;
        d = '0;
        if (c >= 8'h30 && c <= 8'h39)      d = c - 8'h30;
        else if (c >= 8'h41 && c <= 8'h5A) d = c - 8'h37;
        else if (c >= 8'h61 && c <= 8'h7A) d = c - 8'h3D;
        else if (c == 8'h40)               d = 8'd62;
        else if (c == 8'h25)               d = 8'd63;
        else                               return '0;
        return {1'b1, d[SYM_W-1:0]};
    endfunction

endpackage

// File: rtl/codec_char_class.sv
module codec_char_class
    import codec_pkg::*;
#(
    parameter logic [BYTE_W-1:0] NL_CODE   = 8'h0A,
    parameter logic [BYTE_W-1:0] IDLE_CODE = 8'hFF
) (
    input  logic [BYTE_W-1:0] char_in,
    output char_kind_e        kind,
    output logic [SYM_W-1:0]  value
);

    logic [SYM_W:0] lookup;

    always_comb begin
        lookup = char_to_sym(char_in);
        value  = lookup[SYM_W-1:0];
        if (char_in == IDLE_CODE)  kind = K_DROP;
        else if (lookup[SYM_W])    kind = K_SYM;
        else if (char_in == NL_CODE) kind = K_NL;
        else                       kind = K_DROP;
    end

endmodule

// File: rtl/codec_rx_decode.sv
module codec_rx_decode
    import codec_pkg::*;
#(
    parameter logic [BYTE_W-1:0] NL_CODE   = 8'h0A,
    parameter logic [BYTE_W-1:0] IDLE_CODE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    output logic              byte_ready,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SYM_W-1:0]  out_val,
    output logic              out_nl
);

    rx_state_e        state, state_nxt;
    char_kind_e       kind;
    logic [SYM_W-1:0] cls_val;
    logic [SYM_W-1:0] hold_val;
    logic             hold_nl;
    logic             in_fire, keep;

    codec_char_class #(.NL_CODE(NL_CODE), .IDLE_CODE(IDLE_CODE)) u_class (
        .char_in (byte_in),
        .kind    (kind),
        .value   (cls_val)
    );

    assign byte_ready = (state == RX_EMPTY) || out_ready;
    assign in_fire    = byte_valid && byte_ready;
    assign keep       = in_fire && (kind != K_DROP);

    always_comb begin
        state_nxt = state;
        unique case (state)
            RX_EMPTY: state_nxt = keep ? RX_HOLD : RX_EMPTY;
            RX_HOLD:  state_nxt = (keep || !out_ready) ? RX_HOLD : RX_EMPTY;
            default:  state_nxt = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_val <= '0;
            hold_nl  <= 1'b0;
        end else if (keep) begin
            hold_val <= (kind == K_NL) ? '0 : cls_val;
            hold_nl  <= (kind == K_NL);
        end
    end

    always_comb begin
        out_valid = (state == RX_HOLD);
        out_val   = hold_val;
        out_nl    = hold_nl;
    end

    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_val) && $stable(out_nl));

    p_nl_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_nl |-> out_val == '0);

    p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid && byte_valid && byte_ready && kind == K_DROP |=> !out_valid);

    p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && byte_ready && kind != K_DROP |=> out_valid);

endmodule

// File: rtl/codec_tx_encode.sv
module codec_tx_encode
    import codec_pkg::*;
#(
    parameter logic [BYTE_W-1:0] NL_CODE   = 8'h0A,
    parameter logic [BYTE_W-1:0] IDLE_CODE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_valid,
    output logic              sym_ready,
    input  logic [SYM_W-1:0]  sym_val,
    input  logic              sym_nl,
    input  logic              fill_en,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_byte
);

    tx_state_e         state, state_nxt;
    logic [BYTE_W-1:0] hold_byte;
    logic              slot_free, load_sym, load_fill;

    assign slot_free = (state == TX_EMPTY) || out_ready;
    assign load_sym  = slot_free && sym_valid;
    assign load_fill = slot_free && !sym_valid && fill_en;

    always_comb begin
        state_nxt = state;
        unique case (state)
            TX_EMPTY, TX_SYM, TX_FILL: begin
                if (load_sym)        state_nxt = TX_SYM;
                else if (load_fill)  state_nxt = TX_FILL;
                else if (slot_free)  state_nxt = TX_EMPTY;
            end
            default: state_nxt = TX_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hold_byte <= '0;
        else if (load_sym)  hold_byte <= sym_nl ? NL_CODE : sym_to_char(sym_val);
        else if (load_fill) hold_byte <= IDLE_CODE;
    end

    always_comb begin
        sym_ready = slot_free;
        out_valid = (state != TX_EMPTY);
        out_byte  = hold_byte;
    end

    p_tx_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte));

    p_sym_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || out_ready) && sym_valid |=> out_valid && out_byte != IDLE_CODE);

    p_no_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || out_ready) && !sym_valid && !fill_en |=> !out_valid);

    p_nl_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid && sym_ready && sym_nl |=> out_byte == NL_CODE);

endmodule

// File: rtl/sixbit_ascii_codec.sv
module sixbit_ascii_codec
    import codec_pkg::*;
#(
    parameter logic [7:0] NL_CODE   = 8'h0A,
    parameter logic [7:0] IDLE_CODE = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_byte_valid,
    output logic       rx_byte_ready,
    input  logic [7:0] rx_byte,
    output logic       sym_out_valid,
    input  logic       sym_out_ready,
    output logic [5:0] sym_out,
    output logic       sym_out_nl,
    input  logic       sym_in_valid,
    output logic       sym_in_ready,
    input  logic [5:0] sym_in,
    input  logic       sym_in_nl,
    input  logic       idle_fill_en,
    output logic       tx_byte_valid,
    input  logic       tx_byte_ready,
    output logic [7:0] tx_byte
);

    codec_rx_decode #(.NL_CODE(NL_CODE), .IDLE_CODE(IDLE_CODE)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (rx_byte_valid),
        .byte_ready (rx_byte_ready),
        .byte_in    (rx_byte),
        .out_valid  (sym_out_valid),
        .out_ready  (sym_out_ready),
        .out_val    (sym_out),
        .out_nl     (sym_out_nl)
    );

    codec_tx_encode #(.NL_CODE(NL_CODE), .IDLE_CODE(IDLE_CODE)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_in_valid),
        .sym_ready (sym_in_ready),
        .sym_val   (sym_in),
        .sym_nl    (sym_in_nl),
        .fill_en   (idle_fill_en),
        .out_valid (tx_byte_valid),
        .out_ready (tx_byte_ready),
        .out_byte  (tx_byte)
    );

endmodule

// File: tb/sim_sixbit_ascii_codec.sv
module sim_sixbit_ascii_codec;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_byte_valid = 1'b0;
    logic       rx_byte_ready;
    logic [7:0] rx_byte = '0;
    logic       sym_out_valid;
    logic       sym_out_ready = 1'b1;
    logic [5:0] sym_out;
    logic       sym_out_nl;
    logic       sym_in_valid = 1'b0;
    logic       sym_in_ready;
    logic [5:0] sym_in = '0;
    logic       sym_in_nl = 1'b0;
    logic       idle_fill_en = 1'b0;
    logic       tx_byte_valid;
    logic       tx_byte_ready = 1'b1;
    logic [7:0] tx_byte;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit rx_stall = 0, tx_stall = 0, fill_mode = 0, done = 0;
    int fill_cnt = 0;
    int first_fire = -1, last_fire = -1;

    logic [6:0] rxq[$];
    logic [7:0] txq[$];

    sixbit_ascii_codec u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        sym_out_ready = !rx_stall || (cyc % 3 != 0);
        tx_byte_ready = !tx_stall || (cyc % 4 != 1);
    end

    function automatic logic [7:0] exp_char(input int v);
        if (v < 10)       return 8'(8'h30 + v);
        else if (v < 36)  return 8'(8'h41 + v - 10);
        else if (v < 62)  return 8'(8'h61 + v - 36);
        else if (v == 62) return 8'h40;
        return 8'h25;
    endfunction

    function automatic string tag_of(input bit nl, input int v);
        if (nl)          return "R5";
        else if (v < 10) return "R1";
        else if (v < 36) return "R2";
        else if (v < 62) return "R3";
        return "R4";
    endfunction

    task automatic fail(input string req, input string what, input int act, input int exp);
        failures++;
        $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    endtask

    // receive-side monitor
    bit         rx_prev_stall = 0;
    logic [6:0] rx_prev_item = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_prev_stall) begin
                checks++;
                if (!(sym_out_valid && {sym_out_nl, sym_out} == rx_prev_item))
                    fail("R7", "held output changed", {sym_out_nl, sym_out}, rx_prev_item);
            end
            if (sym_out_valid && sym_out_ready) begin
                checks++;
                if (first_fire < 0) first_fire = cyc;
                last_fire = cyc;
                if (rxq.size() == 0)
                    fail("R6", "unexpected rx output", {sym_out_nl, sym_out}, 0);
                else begin
                    logic [6:0] e;
                    e = rxq.pop_front();
                    if ({sym_out_nl, sym_out} != e)
                        fail(tag_of(e[6], int'(e[5:0])), "rx item", {sym_out_nl, sym_out}, e);
                end
            end
            rx_prev_stall = sym_out_valid && !sym_out_ready;
            rx_prev_item  = {sym_out_nl, sym_out};
        end
    end

    // transmit-side monitor
    bit         tx_prev_stall = 0;
    logic [7:0] tx_prev_byte = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_prev_stall) begin
                checks++;
                if (!(tx_byte_valid && tx_byte == tx_prev_byte))
                    fail("R10", "held tx byte changed", tx_byte, tx_prev_byte);
            end
            if (tx_byte_valid && tx_byte_ready) begin
                if (fill_mode && tx_byte == 8'hFF) fill_cnt++;
                else begin
                    checks++;
                    if (txq.size() == 0)
                        fail("R9", "unexpected tx byte", tx_byte, 0);
                    else begin
                        logic [7:0] e;
                        e = txq.pop_front();
                        if (tx_byte != e)
                            fail(e == 8'h0A ? "R8" : "R1", "tx byte", tx_byte, e);
                    end
                end
            end
            tx_prev_stall = tx_byte_valid && !tx_byte_ready;
            tx_prev_byte  = tx_byte;
        end
    end

    task automatic rx_put(input logic [7:0] b, input bit kept, input logic [6:0] e);
        if (kept) rxq.push_back(e);
        rx_byte_valid = 1'b1;
        rx_byte = b;
        forever begin
            @(negedge clk);
            if (rx_byte_ready) break;
        end
        @(posedge clk);
        #1;
        rx_byte_valid = 1'b0;
    endtask

    task automatic tx_put(input bit nl, input logic [5:0] v);
        txq.push_back(nl ? 8'h0A : exp_char(int'(v)));
        sym_in_valid = 1'b1;
        sym_in = v;
        sym_in_nl = nl;
        forever begin
            @(negedge clk);
            if (sym_in_ready) break;
        end
        @(posedge clk);
        #1;
        sym_in_valid = 1'b0;
        sym_in_nl = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && (rxq.size() != 0 || txq.size() != 0); i++)
            @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) fail(req, what, int'(act), int'(exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        logic [7:0] junk [14];
        junk = '{8'hFF, 8'h0D, 8'h20, 8'h2F, 8'h3A, 8'h5B, 8'h60, 8'h7B,
                 8'h7F, 8'h00, 8'h80, 8'h24, 8'h26, 8'h3F};

        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_bit("R11", "sym_out_valid in reset", sym_out_valid, 1'b0);
        check_bit("R11", "tx_byte_valid in reset", tx_byte_valid, 1'b0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R11", "sym_out_valid after reset", sym_out_valid, 1'b0);
        check_bit("R11", "tx_byte_valid after reset", tx_byte_valid, 1'b0);
        check_bit("R11", "rx_byte_ready after reset", rx_byte_ready, 1'b1);
        check_bit("R11", "sym_in_ready after reset", sym_in_ready, 1'b1);
        @(posedge clk); #1;

        // R1 R2 R3 R4: full receive sweep, drops mixed in (R6)
        for (int v = 0; v < 64; v++) begin
            rx_put(exp_char(v), 1, {1'b0, 6'(v)});
            if (v % 8 == 7) rx_put(junk[v / 8], 0, '0);
        end
        drain();

        // R6: only out-of-alphabet bytes
        foreach (junk[i]) rx_put(junk[i], 0, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_bit("R6", "no output after dropped bytes", sym_out_valid, 1'b0);
        check_bit("R6", "no pending expected items", rxq.size() != 0, 1'b0);
        @(posedge clk); #1;

        // R5: newline marker, including behind dropped bytes
        rx_put(8'h0A, 1, 7'b1_000000);
        rx_put(8'h0D, 0, '0);
        rx_put(8'h0A, 1, 7'b1_000000);
        drain();

        // R7: stalled consumer, reversed sweep with newlines
        rx_stall = 1;
        for (int v = 63; v >= 0; v--) begin
            rx_put(exp_char(v), 1, {1'b0, 6'(v)});
            if (v % 16 == 0) rx_put(8'h0A, 1, 7'b1_000000);
            if (v % 10 == 3) rx_put(8'hFF, 0, '0);
        end
        drain();
        rx_stall = 0;
        repeat (2) @(posedge clk); #1;

        // R12: back-to-back throughput
        first_fire = -1;
        for (int k = 0; k < 8; k++) rx_put(exp_char(k * 7), 1, {1'b0, 6'(k * 7)});
        drain();
        checks++;
        if (last_fire - first_fire != 7)
            fail("R12", "burst span in cycles", last_fire - first_fire, 7);

        // transmit sweep (R1 R2 R3 R4 on the tx path)
        for (int v = 0; v < 64; v++) tx_put(0, 6'(v));
        drain();

        // R8: newline ignores value
        tx_put(1, 6'h2A);
        tx_put(1, 6'h3F);
        drain();

        // R10: stalled transport
        tx_stall = 1;
        for (int v = 63; v >= 0; v -= 3) begin
            tx_put(0, 6'(v));
            if (v % 9 == 0) tx_put(1, 6'(v));
        end
        drain();
        tx_stall = 0;

        // R9: no fill without enable
        repeat (5) @(posedge clk);
        @(negedge clk);
        check_bit("R9", "tx idle without fill enable", tx_byte_valid, 1'b0);
        @(posedge clk); #1;

        // R9: fill stream
        fill_mode = 1;
        idle_fill_en = 1'b1;
        repeat (10) @(posedge clk);
        #1;
        checks++;
        if (fill_cnt < 6) fail("R9", "idle bytes sent", fill_cnt, 8);

        // R10: symbols win over fill, also under stall
        tx_put(0, 6'd35);
        tx_put(1, 6'd0);
        tx_stall = 1;
        tx_put(0, 6'd62);
        tx_put(0, 6'd63);
        drain();
        tx_stall = 0;
        idle_fill_en = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_bit("R9", "tx stops after fill disabled", tx_byte_valid, 1'b0);
        fill_mode = 0;
        checks++;
        if (txq.size() != 0 || rxq.size() != 0)
            fail("R10", "items left in queues", txq.size() + rxq.size(), 0);

        finish_run();
    end

endmodule